// File: doc/BRIEF.md
# Cascadable FIFO Slice with Ring Ownership

This block is one slice of a first-in first-out buffer. Several identical slices are wired into a ring to make a deeper buffer. Every slice in the ring shares the write strobe, the read strobe, the input data bus and the output data bus. Two ownership tokens travel around the ring: a write token and a read token. At any moment exactly one slice accepts writes and exactly one slice returns reads. A slice hands a token to its successor over one active-low expansion line, `xo_n`, which drives the successor's `xi_n`. It pulses that line after a write lands in its highest storage location, and again after a read empties that location.

A successor has to know which token a pulse carries. It decides this from a registered copy of the shared strobes: a pulse that follows a write strobe carries the write token, and one that follows a read strobe carries the read token. The successor may use the token in the very cycle the pulse arrives. When a slice gives a token away, the matching pointer wraps to location zero, so the slice can be used again when the token comes back.

Each slice drives its own active-low full and empty flags. A slice that does not own the matching token reports both of its flags as asserted. An external OR of the active-low flags of all slices therefore gives the state of the whole ring.

Inside the slice, ownership is held by a state machine with five states:
- `ST_IDLE`: no token and no data.
- `ST_WRITE`: write token only.
- `ST_BOTH`: both tokens.
- `ST_READ`: read token only.
- `ST_HELD`: no token, but unread data is stored.

The state machine has these named transitions:
- **take-write**: IDLE→WRITE, HELD→WRITE, READ→BOTH.
- **take-read**: HELD→READ, WRITE→BOTH.
- **pass-write**: WRITE→HELD, BOTH→READ.
- **pass-read**: BOTH→WRITE, READ→IDLE.
- **swap**: WRITE→READ, when a read token arrives in the same cycle the write token leaves. READ→WRITE, for the mirror case.

The environment never asserts both strobes in the same clock cycle.

Top module: `ring_fifo_slice`

## Requirements
- R1: While `mrst_n` is low, a slice with `first_n` low resets to owning both tokens (`full_n`=1, `empty_n`=0). A slice with `first_n` high resets to owning neither (`full_n`=0, `empty_n`=0). All slices reset with `xo_n`=1 and `dout_oe`=0.
- R2: Words written through the ring are returned by reads in the order they were written, across slice boundaries.
- R3: A write strobe while the write-owning slice holds DEPTH words is ignored: no word is stored and the slice contents are unchanged.
- R4: A read strobe while the read-owning slice holds no word is ignored. `dout_oe` stays 0 and no word is consumed.
- R5: A write accepted into location DEPTH-1 drives `xo_n` low in the following cycle only, unless a further token hand-off is due.
- R6: A read accepted from location DEPTH-1 drives `xo_n` low in the following cycle only, unless a further token hand-off is due.
- R7: When `xi_n` is low and the previous cycle had the write strobe low (`wr_n`=0), the slice owns the write token from that cycle on. When `xi_n` is low after a read strobe (`rd_n`=0), the slice owns the read token from that cycle on. In both cases the token can be used for an access in that same cycle.
- R8: `dout_oe` is 1 only in a cycle where `rd_n` is 0, the slice owns the read token and the slice holds a word. `dout` is all zeros whenever `dout_oe` is 0. At most one slice of a ring enables its output in any cycle.
- R9: `full_n` is 0 when the slice lacks the write token or holds DEPTH words. `empty_n` is 0 when the slice lacks the read token or holds no word. The OR of these flags over a ring of N slices shows full exactly at N×DEPTH words and empty exactly at zero words.
- R10: Both pointers wrap to location zero when their token is handed off, so words written after the write token returns are stored and read back in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the ring |
| mrst_n | input | 1 | Master reset, active low, asynchronous |
| first_n | input | 1 | Strap, low on the single slice that starts with both tokens |
| wr_n | input | 1 | Shared write strobe, active low |
| rd_n | input | 1 | Shared read strobe, active low |
| din | input | DATA_W | Shared write data |
| xi_n | input | 1 | Expansion input from the predecessor's `xo_n` |
| xo_n | output | 1 | Expansion output, single-cycle low pulse that hands off a token |
| dout | output | DATA_W | Read data, all zeros when not enabled |
| dout_oe | output | 1 | High while this slice drives read data |
| full_n | output | 1 | Local full flag, active low |
| empty_n | output | 1 | Local empty flag, active low |

## Verification
The bench builds a ring of three slices with DEPTH=4 and DATA_W=8. With these values a complete ring fill takes only twelve writes. The tests therefore reach these cases within a few hundred cycles:
- both tokens returning to the first slice;
- a write into locations that were just freed;
- an access issued in the cycle right after a hand-off.

A queue model follows every accepted access, and the ring's combined flags and read data are compared with it each clock. Both sides of each hand-off are also probed at their ports.

// File: rtl/ring_fifo_pkg.sv
package ring_fifo_pkg;

    // Ownership state of one slice in the ring.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,  // no token, no data
        ST_WRITE = 3'd1,  // write token only
        ST_BOTH  = 3'd2,  // write and read token
        ST_READ  = 3'd3,  // read token only
        ST_HELD  = 3'd4   // no token, unread data present
    } tok_state_e;

    function automatic logic holds_wr_tok(tok_state_e s);
        return (s == ST_WRITE) || (s == ST_BOTH);
    endfunction

    function automatic logic holds_rd_tok(tok_state_e s);
        return (s == ST_READ) || (s == ST_BOTH);
    endfunction

endpackage

// File: rtl/ring_fifo_store.sv
module ring_fifo_store #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 8
) (
    input  logic                      clk,
    input  logic                      mrst_n,
    input  logic                      wr_go,
    input  logic                      rd_go,
    input  logic [DATA_W-1:0]         din,
    output logic [DATA_W-1:0]         rdata,
    output logic                      wr_last,
    output logic                      rd_last,
    output logic                      is_full,
    output logic                      is_empty,
    output logic [$clog2(DEPTH)-1:0]  wptr_o,
    output logic [$clog2(DEPTH+1)-1:0] cnt_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_LOC = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAP      = CNT_W'(DEPTH);

    logic [DATA_W-1:0] word_q [DEPTH];
    logic [DEPTH-1:0]  word_we;
    logic [PTR_W-1:0]  wptr, rptr;
    logic [CNT_W-1:0]  cnt;

    // one write enable per storage word
    for (genvar g = 0; g < DEPTH; g++) begin : g_we
        assign word_we[g] = wr_go && (wptr == PTR_W'(g));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (word_we[i]) begin
                word_q[i] <= din;
            end
        end
    end

    assign wr_last  = (wptr == LAST_LOC);
    assign rd_last  = (rptr == LAST_LOC);
    assign is_full  = (cnt == CAP);
    assign is_empty = (cnt == '0);
    assign rdata    = word_q[rptr];
    assign wptr_o   = wptr;
    assign cnt_o    = cnt;

    // pointers wrap to zero exactly when the token leaves
    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (wr_go) begin
                wptr <= wr_last ? '0 : wptr + PTR_W'(1);
            end
            if (rd_go) begin
                rptr <= rd_last ? '0 : rptr + PTR_W'(1);
            end
            cnt <= cnt + CNT_W'(wr_go) - CNT_W'(rd_go);
        end
    end

endmodule

// File: rtl/ring_fifo_ctrl.sv
module ring_fifo_ctrl
    import ring_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       mrst_n,
    input  logic       first_n,
    input  logic       wr_n,
    input  logic       rd_n,
    input  logic       xi_n,
    input  logic       wr_last,
    input  logic       rd_last,
    input  logic       is_full,
    input  logic       is_empty,
    output logic       wr_go,
    output logic       rd_go,
    output logic       own_w,
    output logic       own_r,
    output logic       xo_n,
    output tok_state_e state_o
);
    tok_state_e state, nxt;
    logic       wr_q, rd_q;
    logic       xi_w, xi_r;
    logic       pass_w, pass_r;

    // classify an incoming pulse by the strobe of the previous cycle
    assign xi_w   = !xi_n && wr_q;
    assign xi_r   = !xi_n && rd_q;
    assign own_w  = holds_wr_tok(state) || xi_w;
    assign own_r  = holds_rd_tok(state) || xi_r;
    assign wr_go  = own_w && !wr_n && !is_full;
    assign rd_go  = own_r && !rd_n && !is_empty;
    assign pass_w = wr_go && wr_last;
    assign pass_r = rd_go && rd_last;
    assign state_o = state;

    // state register
    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) begin
            state <= first_n ? ST_IDLE : ST_BOTH;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (xi_w) nxt = ST_WRITE;                    // take-write
            end
            ST_WRITE: begin
                if (pass_w && xi_r)  nxt = ST_READ;          // swap
                else if (pass_w)     nxt = ST_HELD;          // pass-write
                else if (xi_r)       nxt = ST_BOTH;          // take-read
            end
            ST_BOTH: begin
                if (pass_w)          nxt = ST_READ;          // pass-write
                else if (pass_r)     nxt = ST_WRITE;         // pass-read
            end
            ST_READ: begin
                if (pass_r && xi_w)  nxt = ST_WRITE;         // swap
                else if (pass_r)     nxt = ST_IDLE;          // pass-read
                else if (xi_w)       nxt = ST_BOTH;          // take-write
            end
            ST_HELD: begin
                if (xi_r)            nxt = ST_READ;          // take-read
                else if (xi_w)       nxt = ST_WRITE;         // take-write
            end
            default:                 nxt = ST_IDLE;
        endcase
    end

    // registered outputs: hand-off pulse and strobe history
    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) begin
            xo_n <= 1'b1;
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            xo_n <= !(pass_w || pass_r);
            wr_q <= !wr_n;
            rd_q <= !rd_n;
        end
    end

endmodule

// File: rtl/ring_fifo_slice.sv
module ring_fifo_slice
    import ring_fifo_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              first_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [DATA_W-1:0] din,
    input  logic              xi_n,
    output logic              xo_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              full_n,
    output logic              empty_n
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              wr_go, rd_go;
    logic              own_w, own_r;
    logic              wr_last, rd_last;
    logic              is_full, is_empty;
    logic [DATA_W-1:0] rdata;
    logic [PTR_W-1:0]  wptr;
    logic [CNT_W-1:0]  cnt;
    tok_state_e        st;

    ring_fifo_ctrl u_ctrl (
        .clk      (clk),
        .mrst_n   (mrst_n),
        .first_n  (first_n),
        .wr_n     (wr_n),
        .rd_n     (rd_n),
        .xi_n     (xi_n),
        .wr_last  (wr_last),
        .rd_last  (rd_last),
        .is_full  (is_full),
        .is_empty (is_empty),
        .wr_go    (wr_go),
        .rd_go    (rd_go),
        .own_w    (own_w),
        .own_r    (own_r),
        .xo_n     (xo_n),
        .state_o  (st)
    );

    ring_fifo_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk      (clk),
        .mrst_n   (mrst_n),
        .wr_go    (wr_go),
        .rd_go    (rd_go),
        .din      (din),
        .rdata    (rdata),
        .wr_last  (wr_last),
        .rd_last  (rd_last),
        .is_full  (is_full),
        .is_empty (is_empty),
        .wptr_o   (wptr),
        .cnt_o    (cnt)
    );

    // non-owners report asserted flags so an OR forms the ring flag
    assign full_n  = own_w && !is_full;
    assign empty_n = own_r && !is_empty;
    assign dout_oe = rd_go;
    assign dout    = rd_go ? rdata : '0;

endmodule

// File: rtl/ring_fifo_slice_chk.sv
module ring_fifo_slice_chk
    import ring_fifo_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 8
) (
    input logic                        clk,
    input logic                        mrst_n,
    input logic                        wr_n,
    input logic                        rd_n,
    input logic                        xo_n,
    input logic                        dout_oe,
    input logic [DATA_W-1:0]           dout,
    input logic                        empty_n,
    input tok_state_e                  st,
    input logic [$clog2(DEPTH+1)-1:0]  cnt,
    input logic [$clog2(DEPTH)-1:0]    wptr,
    input logic                        wr_go
);
    // R8: output enabled only under a read strobe with data offered
    a_r8_oe_on_read: assert property (@(posedge clk) disable iff (!mrst_n)
        dout_oe |-> (!rd_n && empty_n));

    // R8: quiet bus when not enabled
    a_r8_dout_quiet: assert property (@(posedge clk) disable iff (!mrst_n)
        !dout_oe |-> (dout == '0));

    // R5 / R6: a hand-off pulse always follows an access strobe
    a_r5_xo_after_access: assert property (@(posedge clk) disable iff (!mrst_n)
        !xo_n |-> $past(!wr_n || !rd_n));

    // R3: a full slice keeps its word count under a lone write strobe
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!mrst_n)
        (cnt == ($clog2(DEPTH+1))'(DEPTH) && !wr_n && rd_n) |=> (cnt == ($clog2(DEPTH+1))'(DEPTH)));

    // R4: an empty slice stays empty under a lone read strobe
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!mrst_n)
        (cnt == '0 && !rd_n && wr_n) |=> (cnt == '0));

    // R10: the write pointer returns to zero after the last location
    a_r10_ptr_wrap: assert property (@(posedge clk) disable iff (!mrst_n)
        (wr_go && wptr == ($clog2(DEPTH))'(DEPTH - 1)) |=> (wptr == '0));

    // R9: a slice idle in the ring holds no words
    a_r9_idle_empty: assert property (@(posedge clk) disable iff (!mrst_n)
        (st == ST_IDLE) |-> (cnt == '0));

endmodule

bind ring_fifo_slice ring_fifo_slice_chk #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk     (clk),
    .mrst_n  (mrst_n),
    .wr_n    (wr_n),
    .rd_n    (rd_n),
    .xo_n    (xo_n),
    .dout_oe (dout_oe),
    .dout    (dout),
    .empty_n (empty_n),
    .st      (st),
    .cnt     (cnt),
    .wptr    (wptr),
    .wr_go   (wr_go)
);

// File: tb/ring_fifo_slice_bench.sv
module ring_fifo_slice_bench;
    localparam int W     = 8;
    localparam int D     = 4;
    localparam int N     = 3;
    localparam int CAP   = N * D;

    logic         clk = 1'b0;
    logic         mrst_n;
    logic         wr_n, rd_n;
    logic [W-1:0] din;
    logic [N-1:0] xo_v, full_v, empty_v, oe_v;
    logic [W-1:0] dout_v [N];
    logic [W-1:0] dor;

    int checks = 0;
    int errors = 0;
    int q[$];

    always #10 clk = ~clk;

    for (genvar i = 0; i < N; i++) begin : g_slice
        ring_fifo_slice #(.DATA_W(W), .DEPTH(D)) u_ring_fifo_slice (
            .clk     (clk),
            .mrst_n  (mrst_n),
            .first_n (i != 0),
            .wr_n    (wr_n),
            .rd_n    (rd_n),
            .din     (din),
            .xi_n    (xo_v[(i + N - 1) % N]),
            .xo_n    (xo_v[i]),
            .dout    (dout_v[i]),
            .dout_oe (oe_v[i]),
            .full_n  (full_v[i]),
            .empty_n (empty_v[i])
        );
    end

    always_comb begin
        dor = '0;
        for (int i = 0; i < N; i++) dor = dor | dout_v[i];
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one bus cycle; called at a falling edge, returns at the next one
    task automatic cycle(input bit w, input bit r, input int d);
        bit ef, ff;
        wr_n = !w;
        rd_n = !r;
        din  = W'(d);
        #2;
        ff = (q.size() == CAP);
        ef = (q.size() == 0);
        chk((|full_v) == !ff, "R9 ring full flag", int'(|full_v), int'(!ff));
        chk((|empty_v) == !ef, "R9 ring empty flag", int'(|empty_v), int'(!ef));
        if (r && !ef) begin
            chk($countones(oe_v) == 1, "R8 single output enable", $countones(oe_v), 1);
            chk(int'(dor) == q[0], "R2 read order", int'(dor), q[0]);
        end else begin
            chk(oe_v == '0, "R4/R8 output idle", int'(oe_v), 0);
            chk(dor == '0, "R8 bus quiet", int'(dor), 0);
        end
        @(posedge clk);
        if (w && !ff) q.push_back(d & 255);
        if (r && !ef) void'(q.pop_front());
        @(negedge clk);
        wr_n = 1'b1;
        rd_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        mrst_n = 1'b0;
        wr_n = 1'b1;
        rd_n = 1'b1;
        din = '0;
        repeat (3) @(negedge clk);
        mrst_n = 1'b1;
        @(negedge clk);

        // R1: reset ownership
        chk(full_v == 3'b001, "R1 full flags after reset", int'(full_v), 1);
        chk(empty_v == 3'b000, "R1 empty flags after reset", int'(empty_v), 0);
        chk(xo_v == 3'b111, "R1 xo idle after reset", int'(xo_v), 7);
        chk(oe_v == 3'b000, "R1 oe idle after reset", int'(oe_v), 0);

        // R4: read on empty ring
        cycle(0, 1, 0);
        chk(empty_v == 3'b000, "R4 still empty", int'(empty_v), 0);

        // fill first slice; R5 hand-off after its last location
        for (int k = 1; k <= 4; k++) cycle(1, 0, k);
        chk(xo_v[0] == 1'b0, "R5 xo pulse after last write", int'(xo_v[0]), 0);
        chk(full_v[1] == 1'b1, "R7 successor owns write token", int'(full_v[1]), 1);
        chk(full_v[0] == 1'b0, "R7 predecessor released write", int'(full_v[0]), 0);
        chk(empty_v[0] == 1'b1, "R9 first slice offers data", int'(empty_v[0]), 1);
        cycle(1, 0, 5);   // R7: immediate use of the new token
        chk(xo_v[0] == 1'b1, "R5 pulse lasts one cycle", int'(xo_v[0]), 1);
        chk(full_v[1] == 1'b1, "R7 write token kept", int'(full_v[1]), 1);

        for (int k = 6; k <= 12; k++) cycle(1, 0, k);
        // R3: write into full ring ignored
        cycle(1, 0, 99);
        chk(full_v == 3'b000, "R3 ring stays full", int'(full_v), 0);

        // R10: free two words, reuse the first slice
        cycle(0, 1, 0);
        cycle(0, 1, 0);
        cycle(1, 0, 13);
        cycle(1, 0, 14);
        cycle(0, 1, 0);
        cycle(0, 1, 0);   // takes last location of first slice
        chk(xo_v[0] == 1'b0, "R6 xo pulse after last read", int'(xo_v[0]), 0);
        chk(empty_v[1] == 1'b1, "R7 successor owns read token", int'(empty_v[1]), 1);
        chk(empty_v[0] == 1'b0, "R7 predecessor released read", int'(empty_v[0]), 0);
        chk(full_v[0] == 1'b1, "R10 first slice writable again", int'(full_v[0]), 1);
        while (q.size() > 0) cycle(0, 1, 0);
        cycle(0, 1, 0);

        // mixed traffic, alternating bias to reach both boundaries
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            bit w, r;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (((i / 100) % 2) == 0) begin
                w = (lfsr[3:0] < 4'd10);
                r = !w && (lfsr[3:0] < 4'd13);
            end else begin
                w = (lfsr[3:0] < 4'd5);
                r = !w && (lfsr[3:0] < 4'd14);
            end
            cycle(w, r, int'(lfsr[11:4]));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule